// File: doc/BRIEF.md
# Dual-Channel Down-Counting Event Timer

This peripheral holds a small set of independent down-counters behind a plain synchronous register bus. Each channel picks one of several tick-enable inputs, divides it by a power of two, and decrements its count on every divided tick. When the count is already zero at a divided tick, the channel reports an expiry. In periodic mode it then reloads its interval. In one-shot mode it halts and drops its own enable bit.

Expiries latch into a shared status register that software clears by writing ones. A shared enable register masks the status bits onto a single interrupt line. Stopping a channel is not immediate. A channel that is told to stop keeps counting until two ticks of its selected source have passed, so software has to allow for that settling time. A channel loaded with an all-ones interval and left periodic acts as a free-running down-counter that can be read at any time.

Top module: `evt_timer`

## Requirements
- R1: After reset every readable register (interrupt enable at 0x00, status at 0x04, and each channel's control, interval and count) reads 0, and `irq` is low.
- R2: Channel n's control register sits at 0x10+0x10·n: bit 0 enable, bit 1 reload, bits 3:2 source, bits 6:4 prescale, bit 7 one-shot. A write with enable and reload both set copies the interval (0x14+0x10·n) into the count (0x18+0x10·n). The reload bit always reads back 0, and the other fields read back as written.
- R3: While running, the count drops by one per divided tick. With prescale value N, a divided tick happens on every 2^N-th selected source tick, and the first one comes 2^N source ticks after a reload start.
- R4: Source code 1 selects `ref_tick`. Codes 0, 2 and 3 select `aux_tick[0]`, `aux_tick[1]` and `aux_tick[2]`. Ticks on inputs that are not selected leave the count unchanged.
- R5: In periodic mode (bit 7 clear), a divided tick that finds the count at 0 sets the channel's status bit and reloads the interval, giving a period of interval+1 divided ticks.
- R6: In one-shot mode, a divided tick that finds the count at 0 sets the status bit and halts the channel. The count stays 0, the enable bit reads 0, and no further expiry follows without a new control write.
- R7: Writing 1 to a status bit (0x04, bit n = channel n) clears it, and writing 0 leaves it. An expiry in the same cycle as a clearing write leaves the bit set.
- R8: `irq` is high exactly when some status bit is set together with its enable bit at 0x00.
- R9: After a control write with enable clear to a running channel, counting continues until two selected source ticks have occurred, after which the count holds.
- R10: Writing the interval does not change a running count. The new value is used at the next reload.
- R11: The count register is read-only, and bus writes to it have no effect.
- R12: A control write with enable set and reload clear restarts a halted channel from its held count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ref_tick | input | 1 | Main reference tick enable (source code 1) |
| aux_tick | input | 3 | Auxiliary tick enables (source codes 0, 2, 3) |
| irq | output | 1 | Masked OR of the status bits |

## Verification
The bench uses the default build: two channels, 32-bit counters, a three-bit prescale field and a two-tick stop delay. Directed sequences use intervals below sixteen, so reload, one-shot halting, the stop delay, prescale division and the set-versus-clear collision all happen within a few dozen cycles. A random phase then drives all four tick inputs and bus writes with every prescale value up to divide-by-128. A behavioural model is compared against `irq` and the read data on every cycle. The wrap of a full 32-bit count is out of reach at these lengths.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int PSC_W = 3;
  localparam int SRC_W = 2;
  localparam int NSRC  = 1 << SRC_W;
  localparam int DIV_W = (1 << PSC_W) - 1;

  // control word; bit positions are decoded by software
  typedef struct packed {
    logic             one;
    logic [PSC_W-1:0] psc;
    logic [SRC_W-1:0] src;
    logic             rld;
    logic             en;
  } tmr_ctl_t;

  localparam int CTL_W = $bits(tmr_ctl_t);

  localparam logic [3:0] REG_CTL  = 4'h0;
  localparam logic [3:0] REG_INTV = 4'h4;
  localparam logic [3:0] REG_CNT  = 4'h8;
endpackage

// File: rtl/tmr_prescale.sv
`timescale 1ns/1ps
module tmr_prescale
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PSC_W-1:0] psc_i,
  input  logic             src_tk_i,
  input  logic             run_i,
  input  logic             restart_i,
  output logic             pre_tk_o
);
  logic [DIV_W-1:0] pc_q, pc_d;
  logic [DIV_W-1:0] mask;

  always_comb begin
    mask     = ~({DIV_W{1'b1}} << psc_i);
    pre_tk_o = run_i && src_tk_i && ((pc_q & mask) == mask);
    pc_d     = pc_q;
    if (restart_i || !run_i) begin
      pc_d = '0;
    end else if (src_tk_i) begin
      pc_d = pc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else begin
      pc_q <= pc_d;
    end
  end

  // R3
  psc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_tk_o && psc_i != '0) |=> (!pre_tk_o || psc_i != $past(psc_i)));
endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int STOP_TICKS = 2,
  localparam int SCNT_W    = $clog2(STOP_TICKS + 1)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic             intv_we,
  input  logic [CNT_W-1:0] wdata,
  input  logic [NSRC-1:0]  tick_vec,
  output tmr_ctl_t         ctl_o,
  output logic [CNT_W-1:0] intv_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  tmr_ctl_t         ctl_q, ctl_d, wctl;
  logic [CNT_W-1:0] intv_q, intv_d, cnt_q, cnt_d;
  logic             act_q, act_d, stop_q, stop_d;
  logic [SCNT_W-1:0] scnt_q, scnt_d;
  logic             src_tk, pre_tk, restart, expire;

  assign wctl    = tmr_ctl_t'(wdata[CTL_W-1:0]);
  assign src_tk  = tick_vec[ctl_q.src];
  assign restart = ctl_we && wctl.en && wctl.rld;
  assign expire  = !ctl_we && pre_tk && (cnt_q == '0);

  tmr_prescale u_psc (
    .clk       (clk),
    .rst_n     (rst_n),
    .psc_i     (ctl_q.psc),
    .src_tk_i  (src_tk),
    .run_i     (act_q),
    .restart_i (restart),
    .pre_tk_o  (pre_tk)
  );

  always_comb begin
    ctl_d  = ctl_q;
    intv_d = intv_q;
    cnt_d  = cnt_q;
    act_d  = act_q;
    stop_d = stop_q;
    scnt_d = scnt_q;
    if (intv_we) begin
      intv_d = wdata;
    end
    if (ctl_we) begin
      ctl_d     = wctl;
      ctl_d.rld = 1'b0;
      if (wctl.en) begin
        act_d  = 1'b1;
        stop_d = 1'b0;
        if (wctl.rld) begin
          cnt_d = intv_q;
        end
      end else if (act_q) begin
        stop_d = 1'b1;
        scnt_d = '0;
      end
    end else begin
      if (pre_tk) begin
        if (cnt_q == '0) begin
          if (ctl_q.one) begin
            act_d    = 1'b0;
            stop_d   = 1'b0;
            ctl_d.en = 1'b0;
          end else begin
            cnt_d = intv_q;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      if (stop_q && src_tk && !(expire && ctl_q.one)) begin
        if (scnt_q == SCNT_W'(STOP_TICKS - 1)) begin
          act_d  = 1'b0;
          stop_d = 1'b0;
          scnt_d = '0;
        end else begin
          scnt_d = scnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      intv_q <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
      stop_q <= 1'b0;
      scnt_q <= '0;
    end else begin
      ctl_q  <= ctl_d;
      intv_q <= intv_d;
      cnt_q  <= cnt_d;
      act_q  <= act_d;
      stop_q <= stop_d;
      scnt_q <= scnt_d;
    end
  end

  assign ctl_o    = ctl_q;
  assign intv_o   = intv_q;
  assign cnt_o    = cnt_q;
  assign expire_o = expire;

  // R9
  halt_needs_srctick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !src_tk && !ctl_we) |=> act_q);
  // R6
  oneshot_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && ctl_q.one) |=> (!act_q && cnt_q == '0 && !ctl_q.en));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q && !ctl_we) |=> $stable(cnt_q));
  // R2
  rld_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> !ctl_q.rld);
endmodule

// File: rtl/tmr_irq.sv
`timescale 1ns/1ps
module tmr_irq #(
  parameter int NUM_CH = 2
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ien_we,
  input  logic              sts_we,
  input  logic [NUM_CH-1:0] wdata,
  input  logic [NUM_CH-1:0] set_i,
  output logic [NUM_CH-1:0] ien_o,
  output logic [NUM_CH-1:0] sts_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] ien_q, ien_d, sts_q, sts_d, clr;

  always_comb begin
    clr   = sts_we ? wdata : '0;
    ien_d = ien_we ? wdata : ien_q;
    sts_d = (sts_q & ~clr) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= '0;
      sts_q <= '0;
    end else begin
      ien_q <= ien_d;
      sts_q <= sts_d;
    end
  end

  assign ien_o = ien_q;
  assign sts_o = sts_q;
  assign irq_o = |(sts_q & ien_q);

  // R7
  sts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((sts_q & $past(set_i)) == $past(set_i)));
  // R7
  sts_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_we |=> ((sts_q & $past(wdata & ~set_i)) == '0));
  // R8
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_we && wdata == '0) |=> !irq_o);
endmodule

// File: rtl/evt_timer.sv
`timescale 1ns/1ps
module evt_timer
  import tmr_pkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter int CNT_W      = 32,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 8,
  parameter int STOP_TICKS = 2,
  parameter int REF_CODE   = 1,
  localparam int NUM_AUX   = NSRC - 1
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic               ref_tick,
  input  logic [NUM_AUX-1:0] aux_tick,
  output logic               irq
);
  localparam int BLK_W = ADDR_W - 4;

  logic [NSRC-1:0]   tick_vec;
  logic [BLK_W-1:0]  blk;
  logic [3:0]        ofs;
  logic              aligned;
  logic [NUM_CH-1:0] ctl_we, intv_we, expire, ien, sts;
  tmr_ctl_t          ctl_a  [NUM_CH];
  logic [CNT_W-1:0]  intv_a [NUM_CH];
  logic [CNT_W-1:0]  cnt_a  [NUM_CH];

  assign blk     = bus_addr[ADDR_W-1:4];
  assign ofs     = bus_addr[3:0];
  assign aligned = (bus_addr[1:0] == 2'b00);

  // R4: source code to tick input mapping
  for (genvar k = 0; k < NSRC; k++) begin : g_src
    if (k == REF_CODE) begin : g_ref
      assign tick_vec[k] = ref_tick;
    end else if (k < REF_CODE) begin : g_lo
      assign tick_vec[k] = aux_tick[k];
    end else begin : g_hi
      assign tick_vec[k] = aux_tick[k-1];
    end
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    assign ctl_we[n]  = bus_we && aligned && (blk == BLK_W'(n + 1)) && (ofs == REG_CTL);
    assign intv_we[n] = bus_we && aligned && (blk == BLK_W'(n + 1)) && (ofs == REG_INTV);

    tmr_channel #(
      .CNT_W      (CNT_W),
      .STOP_TICKS (STOP_TICKS)
    ) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_we   (ctl_we[n]),
      .intv_we  (intv_we[n]),
      .wdata    (bus_wdata[CNT_W-1:0]),
      .tick_vec (tick_vec),
      .ctl_o    (ctl_a[n]),
      .intv_o   (intv_a[n]),
      .cnt_o    (cnt_a[n]),
      .expire_o (expire[n])
    );
  end

  tmr_irq #(.NUM_CH(NUM_CH)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .ien_we (bus_we && aligned && bus_addr == ADDR_W'(0)),
    .sts_we (bus_we && aligned && bus_addr == ADDR_W'(4)),
    .wdata  (bus_wdata[NUM_CH-1:0]),
    .set_i  (expire),
    .ien_o  (ien),
    .sts_o  (sts),
    .irq_o  (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      if (bus_addr == ADDR_W'(0)) begin
        bus_rdata = DATA_W'(ien);
      end else if (bus_addr == ADDR_W'(4)) begin
        bus_rdata = DATA_W'(sts);
      end
      for (int n = 0; n < NUM_CH; n++) begin
        if (blk == BLK_W'(n + 1)) begin
          case (ofs)
            REG_CTL:  bus_rdata = DATA_W'(ctl_a[n]);
            REG_INTV: bus_rdata = DATA_W'(intv_a[n]);
            REG_CNT:  bus_rdata = DATA_W'(cnt_a[n]);
            default:  bus_rdata = '0;
          endcase
        end
      end
    end
  end

  // R11
  cnt_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(8'h18) && !$past(ctl_we[0]) && ctl_a[0].en == 1'b0
      && !ctl_we[0]) |=> $stable(cnt_a[0]));
endmodule

// File: tb/sim_evt_timer.sv
`timescale 1ns/1ps
module sim_evt_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ref_tick = 1'b0;
  logic [2:0]  aux_tick = '0;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  evt_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ref_tick(ref_tick),
    .aux_tick(aux_tick), .irq(irq)
  );

  // behavioural reference model
  int unsigned m_cnt[2], m_intv[2];
  int m_en[2], m_src[2], m_psc[2], m_one[2], m_act[2], m_stop[2], m_scnt[2], m_pc[2];
  int m_ien, m_sts;

  function automatic int src_tick(int code);
    case (code)
      1: return int'(ref_tick);
      0: return int'(aux_tick[0]);
      2: return int'(aux_tick[1]);
      default: return int'(aux_tick[2]);
    endcase
  endfunction

  function automatic logic [31:0] mread(logic [7:0] a);
    if (a == 8'h00) return 32'(m_ien);
    if (a == 8'h04) return 32'(m_sts);
    for (int c = 0; c < 2; c++) begin
      if (a == 8'(16 + 16*c)) return 32'(m_one[c]*128 + m_psc[c]*16 + m_src[c]*4 + m_en[c]);
      if (a == 8'(20 + 16*c)) return m_intv[c];
      if (a == 8'(24 + 16*c)) return m_cnt[c];
    end
    return 32'd0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_cnt[c] = 0; m_intv[c] = 0; m_en[c] = 0; m_src[c] = 0; m_psc[c] = 0;
        m_one[c] = 0; m_act[c] = 0; m_stop[c] = 0; m_scnt[c] = 0; m_pc[c] = 0;
      end
      m_ien = 0; m_sts = 0;
    end else begin
      int nsts;
      nsts = m_sts;
      if (bus_we && bus_addr == 8'h04) nsts = nsts & ~int'(bus_wdata[1:0]);
      for (int c = 0; c < 2; c++) begin
        int tk, ptk, ex, div;
        bit cw;
        tk  = src_tick(m_src[c]);
        div = 1 << m_psc[c];
        ptk = (m_act[c] != 0 && tk != 0 && (m_pc[c] % div) == div - 1) ? 1 : 0;
        cw  = bus_we && bus_addr == 8'(16 + 16*c);
        ex  = 0;
        if (cw) begin
          m_en[c]  = int'(bus_wdata[0]);
          m_src[c] = int'(bus_wdata[3:2]);
          m_psc[c] = int'(bus_wdata[6:4]);
          m_one[c] = int'(bus_wdata[7]);
          if (bus_wdata[0]) begin
            if (bus_wdata[1]) begin
              m_cnt[c] = m_intv[c];
              m_pc[c] = 0;
            end else if (m_act[c] != 0 && tk != 0) m_pc[c] = (m_pc[c] + 1) % 128;
            else if (m_act[c] == 0) m_pc[c] = 0;
            m_act[c] = 1; m_stop[c] = 0;
          end else begin
            if (m_act[c] != 0) begin
              if (tk != 0) m_pc[c] = (m_pc[c] + 1) % 128;
              m_stop[c] = 1; m_scnt[c] = 0;
            end else m_pc[c] = 0;
          end
        end else begin
          int was_act, was_stop, one_now;
          was_act = m_act[c]; was_stop = m_stop[c]; one_now = m_one[c];
          if (ptk != 0) begin
            if (m_cnt[c] == 0) begin
              ex = 1;
              if (one_now != 0) begin
                m_act[c] = 0; m_stop[c] = 0; m_en[c] = 0;
              end else m_cnt[c] = m_intv[c];
            end else m_cnt[c] = m_cnt[c] - 1;
          end
          if (was_stop != 0 && tk != 0 && !(ex != 0 && one_now != 0)) begin
            if (m_scnt[c] == 1) begin
              m_act[c] = 0; m_stop[c] = 0; m_scnt[c] = 0;
            end else m_scnt[c] = m_scnt[c] + 1;
          end
          if (was_act == 0) m_pc[c] = 0;
          else if (tk != 0) m_pc[c] = (m_pc[c] + 1) % 128;
        end
        if (bus_we && bus_addr == 8'(20 + 16*c)) m_intv[c] = bus_wdata;
        if (ex != 0) nsts = nsts | (1 << c);
      end
      if (bus_we && bus_addr == 8'h00) m_ien = int'(bus_wdata[1:0]);
      m_sts = nsts;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    #5;
    if (rst_n && !done) begin
      string tag;
      chk("R8 irq", 32'(irq), 32'((m_sts & m_ien) != 0));
      if (bus_addr == 8'h00) tag = "R8 ien";
      else if (bus_addr == 8'h04) tag = "R7 sts";
      else if (bus_addr[3:0] == 4'h0) tag = "R2 ctl";
      else if (bus_addr[3:0] == 4'h4) tag = "R10 intv";
      else tag = "R3 cnt";
      chk(tag, bus_rdata, mread(bus_addr));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #5;
    chk(tag, bus_rdata, exp);
  endtask

  // which: bit0 ref_tick, bits 3:1 aux_tick[2:0]
  task automatic ticks(input int n, input logic [3:0] which);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ref_tick = which[0];
      aux_tick = which[3:1];
    end
    @(negedge clk);
    ref_tick = 1'b0;
    aux_tick = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] lfsr;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_chk("R1 ien", 8'h00, 0);
    rd_chk("R1 sts", 8'h04, 0);
    rd_chk("R1 ctl1", 8'h20, 0);
    rd_chk("R1 cnt0", 8'h18, 0);
    chk("R1 irq", 32'(irq), 0);

    // R2 reload start, periodic, ref source, prescale 0
    wr(8'h14, 5);
    wr(8'h00, 1);
    wr(8'h10, 32'h07);
    rd_chk("R2 cnt loaded", 8'h18, 5);
    rd_chk("R2 ctl readback", 8'h10, 32'h05);
    ticks(3, 4'b0001);
    rd_chk("R3 count down", 8'h18, 2);
    ticks(3, 4'b0001);
    rd_chk("R5 reload", 8'h18, 5);
    rd_chk("R5 status", 8'h04, 1);
    chk("R8 irq set", 32'(irq), 1);
    wr(8'h04, 0);
    rd_chk("R7 write zero keeps", 8'h04, 1);
    wr(8'h04, 1);
    rd_chk("R7 write one clears", 8'h04, 0);
    chk("R8 irq clear", 32'(irq), 0);
    ticks(3, 4'b1110);
    rd_chk("R4 unselected aux", 8'h18, 5);

    // R3 prescale by 4
    wr(8'h10, 32'h27);
    ticks(3, 4'b0001);
    rd_chk("R3 psc before", 8'h18, 5);
    ticks(1, 4'b0001);
    rd_chk("R3 psc first", 8'h18, 4);
    ticks(8, 4'b0001);
    rd_chk("R3 psc two more", 8'h18, 2);
    // R10 interval write while running
    wr(8'h14, 9);
    rd_chk("R10 count kept", 8'h18, 2);
    ticks(12, 4'b0001);
    rd_chk("R10 new reload", 8'h18, 9);
    rd_chk("R5 status psc", 8'h04, 1);
    wr(8'h04, 1);

    // R9 delayed disable
    wr(8'h10, 32'h07);
    ticks(2, 4'b0001);
    rd_chk("R9 before stop", 8'h18, 7);
    wr(8'h10, 32'h04);
    ticks(2, 4'b0001);
    rd_chk("R9 two more ticks", 8'h18, 5);
    ticks(3, 4'b0001);
    rd_chk("R9 halted", 8'h18, 5);
    rd_chk("R9 ctl", 8'h10, 32'h04);
    // R12 resume without reload
    wr(8'h10, 32'h05);
    ticks(2, 4'b0001);
    rd_chk("R12 resume", 8'h18, 3);

    // R6 one-shot
    wr(8'h14, 2);
    wr(8'h10, 32'h87);
    ticks(3, 4'b0001);
    rd_chk("R6 count zero", 8'h18, 0);
    rd_chk("R6 enable dropped", 8'h10, 32'h84);
    rd_chk("R6 status", 8'h04, 1);
    wr(8'h04, 1);
    ticks(5, 4'b0001);
    rd_chk("R6 no re-expiry", 8'h04, 0);
    rd_chk("R6 still zero", 8'h18, 0);
    // R11 count read-only
    wr(8'h18, 123);
    rd_chk("R11 count write ignored", 8'h18, 0);

    // R4 channel 1 on aux_tick[1] (code 2)
    wr(8'h24, 10);
    wr(8'h20, 32'h0B);
    ticks(4, 4'b0001);
    rd_chk("R4 ref ignored", 8'h28, 10);
    ticks(3, 4'b0100);
    rd_chk("R4 aux1 counts", 8'h28, 7);
    ticks(2, 4'b1010);
    rd_chk("R4 aux0 aux2 ignored", 8'h28, 7);

    // R8 masking
    wr(8'h24, 1);
    wr(8'h20, 32'h0B);
    ticks(2, 4'b0100);
    rd_chk("R8 sts ch1", 8'h04, 2);
    chk("R8 masked", 32'(irq), 0);
    wr(8'h00, 3);
    chk("R8 unmasked", 32'(irq), 1);
    wr(8'h00, 1);
    chk("R8 masked again", 32'(irq), 0);

    // R7 set wins over clear
    wr(8'h24, 0);
    wr(8'h20, 32'h0B);
    @(negedge clk);
    aux_tick = 3'b010;
    wr(8'h04, 2);
    #5;
    chk("R7 set beats clear", bus_rdata, 2);
    @(negedge clk);
    aux_tick = '0;
    wr(8'h04, 2);
    #5;
    chk("R7 cleared", bus_rdata, 0);

    // random phase, compared each cycle against the model
    lfsr = 32'hACE1_2357;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      ref_tick = lfsr[3];
      aux_tick = lfsr[6:4];
      bus_we = (lfsr[11:8] == 4'h0);
      case (lfsr[15:12] % 9)
        0: bus_addr = 8'h00;
        1: bus_addr = 8'h04;
        2: bus_addr = 8'h10;
        3: bus_addr = 8'h14;
        4: bus_addr = 8'h18;
        5: bus_addr = 8'h20;
        6: bus_addr = 8'h24;
        7: bus_addr = 8'h28;
        default: bus_addr = 8'h30;
      endcase
      if (bus_addr[3:0] == 4'h4 && bus_addr != 8'h04) bus_wdata = {28'd0, lfsr[19:16]};
      else bus_wdata = {lfsr[7:0], lfsr[31:24], lfsr[15:8], lfsr[23:16]};
    end
    @(negedge clk);
    bus_we = 1'b0;
    ref_tick = 1'b0;
    aux_tick = '0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule